// File: doc/BRIEF.md
# Quadrature and Pulse Position Counter

This block keeps a signed position count driven by two asynchronous digital inputs, A and B. In single-phase mode every rising edge of A moves the count by one step, and a direction bit chooses the sign of that step. In quadrature mode the count follows the phase relation between A and B. The multiplier picks how many of the four edges in each cycle are counted: one, two or four.

Both inputs go through a two-flop synchronizer. In single-phase mode, A then passes a programmable stability filter. In quadrature mode the filter is bypassed. An enable input freezes the count and the status flag. A synchronous clear takes priority over counting. A status flag reports when the count equals a set value. A sticky error bit records any cycle in which both quadrature inputs toggle together. All configuration values are static ports.

Top module: `quad_pulse_counter`

## Requirements
- R1: In single-phase mode (`quad_mode`=0), each rising edge of filtered A adds 1 to the count when `single_down`=0 and subtracts 1 when `single_down`=1. B has no effect in this mode.
- R2: With `quad_mode`=1 and `mult`=0 (1x), a B rise while A is high adds 1 and a B fall while A is high subtracts 1. No other edge changes the count.
- R3: With `mult`=1 (2x), the count rises on a B rise with A high or a B fall with A low. It falls on a B fall with A high or a B rise with A low. Edges on A are not counted.
- R4: With `mult`=2 or 3 (4x), the count rises on each of these edges: A rise with B low, B rise with A high, A fall with B high, B fall with A low. It falls on the four opposite edges. A full forward cycle therefore adds 4.
- R5: In quadrature mode, if synchronized A and B change in the same clock cycle, the count does not change and `dual_err` goes high. It stays high until clear or reset.
- R6: The count is a `CNT_W`-bit two's-complement value that wraps from the largest positive value to the most negative value when stepping up, and the other way when stepping down.
- R7: While `enable` is low and `clear` is low, `count` and `reached` keep their values, whatever the inputs and `set_value` do.
- R8: While enabled, `reached` is high exactly when the count equals `set_value`. It is updated in the same cycle as the count.
- R9: `clear` loads zero into the count and drops `dual_err`. It sets `reached` to (`set_value`==0). It takes priority over counting and acts even when `enable` is low.
- R10: In single-phase mode, filtered A changes only after synchronized A has differed from it for `filt_len` consecutive clocks. A `filt_len` of 0 means one clock. Quadrature mode uses the unfiltered synchronized inputs.
- R11: In quadrature mode, `single_down` has no effect on counting.
- R12: After reset, `count`=0, `reached`=0 and `dual_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of count and error |
| enable | input | 1 | Counting enable |
| in_a | input | 1 | Raw phase A input |
| in_b | input | 1 | Raw phase B input |
| quad_mode | input | 1 | 0 = single-phase, 1 = quadrature |
| single_down | input | 1 | Single-phase direction, 1 = count down |
| mult | input | 2 | Quadrature multiplier: 0 = 1x, 1 = 2x, 2/3 = 4x |
| filt_len | input | FLT_W | Filter length in system clocks (0 = 1) |
| set_value | input | CNT_W | Signed compare value |
| count | output | CNT_W | Signed position count |
| reached | output | 1 | Count equals set value |
| dual_err | output | 1 | Sticky simultaneous-edge error |

## Verification
The bench builds the counter with `CNT_W`=8 and `FLT_W`=11. The narrow width puts wrap-around in both directions within about 130 pulses. The 11-bit filter field still covers the full 0 to 1700 range, so a 20-clock filter setting can show one pulse rejected and one passed. Quadrature sequences run in both rotation directions under each multiplier. One quadrature run switches edges faster than the filter setting, which shows that quadrature mode bypasses the filter.

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter #(
  parameter int CNT_W = 32,
  parameter int FLT_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    enable,
  input  logic                    in_a,
  input  logic                    in_b,
  input  logic                    quad_mode,
  input  logic                    single_down,
  input  logic [1:0]              mult,
  input  logic [FLT_W-1:0]        filt_len,
  input  logic signed [CNT_W-1:0] set_value,
  output logic signed [CNT_W-1:0] count,
  output logic                    reached,
  output logic                    dual_err
);

  logic [1:0] a_sy, b_sy;
  logic a_p, b_p, a_f, a_fp;
  logic [FLT_W-1:0] flt_cnt;

  wire a_s = a_sy[1];
  wire b_s = b_sy[1];
  wire [FLT_W-1:0] flt_n = (filt_len == '0) ? FLT_W'(1) : filt_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sy <= '0;
      b_sy <= '0;
      a_p  <= 1'b0;
      b_p  <= 1'b0;
      a_fp <= 1'b0;
    end else begin
      a_sy <= {a_sy[0], in_a};
      b_sy <= {b_sy[0], in_b};
      a_p  <= a_s;
      b_p  <= b_s;
      a_fp <= a_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_f     <= 1'b0;
      flt_cnt <= '0;
    end else if (a_s == a_f) begin
      flt_cnt <= '0;
    end else if ({1'b0, flt_cnt} + 1'b1 >= {1'b0, flt_n}) begin
      a_f     <= a_s;
      flt_cnt <= '0;
    end else begin
      flt_cnt <= flt_cnt + 1'b1;
    end
  end

  wire da   = a_s ^ a_p;
  wire db   = b_s ^ b_p;
  wire same = ~(a_s ^ b_s);
  wire dual = quad_mode & da & db;
  wire rise_af = a_f & ~a_fp;

  logic up, dn;
  always_comb begin
    up = 1'b0;
    dn = 1'b0;
    if (!quad_mode) begin
      up = rise_af & ~single_down;
      dn = rise_af & single_down;
    end else if (!dual) begin
      case (mult)
        2'd0: begin
          up = db & a_s & b_s;
          dn = db & a_s & ~b_s;
        end
        2'd1: begin
          up = db & same;
          dn = db & ~same;
        end
        default: begin
          up = (db & same) | (da & ~same);
          dn = (db & ~same) | (da & same);
        end
      endcase
    end
  end

  wire signed [CNT_W-1:0] cnt_nxt = up ? count + 1'b1 : (dn ? count - 1'b1 : count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      reached  <= 1'b0;
      dual_err <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      reached  <= (set_value == '0);
      dual_err <= 1'b0;
    end else if (enable) begin
      count   <= cnt_nxt;
      reached <= (cnt_nxt == set_value);
      if (dual) dual_err <= 1'b1;
    end
  end

endmodule

// File: rtl/quad_pulse_counter_chk.sv
module quad_pulse_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clear,
  input logic                    enable,
  input logic signed [CNT_W-1:0] set_value,
  input logic signed [CNT_W-1:0] count,
  input logic                    reached,
  input logic                    dual_err
);

  // R7
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> $stable(count));

  // R7
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> $stable(reached));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0) && !dual_err && (reached == ($past(set_value) == '0)));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_err && !clear) |=> dual_err);

  // R6
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count == $past(count)) ||
               (count == CNT_W'($past(count) + 1'b1)) ||
               (count == CNT_W'($past(count) - 1'b1)));

  // R8
  reached_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clear) |=> (reached == (count == $past(set_value))));

endmodule

bind quad_pulse_counter quad_pulse_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
  .set_value(set_value), .count(count), .reached(reached), .dual_err(dual_err)
);

// File: tb/tb_quad_pulse_counter.sv
module tb_quad_pulse_counter;
  localparam int CW = 8;
  localparam int FW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, enable = 1'b0, in_a = 1'b0, in_b = 1'b0;
  logic quad_mode = 1'b0, single_down = 1'b0;
  logic [1:0] mult = 2'd0;
  logic [FW-1:0] filt_len = '0;
  logic signed [CW-1:0] set_value = '0;
  logic signed [CW-1:0] count;
  logic reached, dual_err;

  int total = 0;
  int bad = 0;
  int settle = 8;

  always #5 clk = ~clk;

  quad_pulse_counter #(.CNT_W(CW), .FLT_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .enable(enable),
    .in_a(in_a), .in_b(in_b), .quad_mode(quad_mode), .single_down(single_down),
    .mult(mult), .filt_len(filt_len), .set_value(set_value),
    .count(count), .reached(reached), .dual_err(dual_err)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1; cyc(1); clear = 1'b0; cyc(1);
  endtask

  task automatic step(input logic a, input logic b, input int hold);
    in_a = a; in_b = b; cyc(hold);
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1, in_b, settle);
      step(1'b0, in_b, settle);
    end
  endtask

  task automatic fwd(input int hold);
    step(1, 0, hold); step(1, 1, hold); step(0, 1, hold); step(0, 0, hold);
  endtask

  task automatic rev(input int hold);
    step(0, 1, hold); step(1, 1, hold); step(1, 0, hold); step(0, 0, hold);
  endtask

  task automatic t_reset();
    chk("R12 count", int'(count), 0);
    chk("R12 reached", int'(reached), 0);
    chk("R12 dual_err", int'(dual_err), 0);
  endtask

  task automatic t_single();
    quad_mode = 0; single_down = 0; set_value = 8'sd100; do_clear();
    pulse_a(3);
    chk("R1 up", int'(count), 3);
    step(0, 1, settle); step(0, 0, settle);
    chk("R1 B ignored", int'(count), 3);
    single_down = 1; pulse_a(5);
    chk("R1 down", int'(count), -2);
  endtask

  task automatic t_x1();
    quad_mode = 1; mult = 2'd0; do_clear();
    fwd(6); fwd(6);
    chk("R2 1x forward", int'(count), 2);
    rev(6);
    chk("R2 1x reverse", int'(count), 1);
  endtask

  task automatic t_x2();
    mult = 2'd1; do_clear();
    fwd(6);
    chk("R3 2x forward", int'(count), 2);
    rev(6); rev(6);
    chk("R3 2x reverse", int'(count), -2);
  endtask

  task automatic t_x4();
    mult = 2'd2; do_clear();
    fwd(6);
    chk("R4 4x forward", int'(count), 4);
    step(1, 0, 6);
    chk("R4 A rise B low", int'(count), 5);
    step(0, 0, 6);
    chk("R4 A fall B low", int'(count), 4);
    rev(6);
    chk("R4 4x reverse", int'(count), 0);
    mult = 2'd3; fwd(6);
    chk("R4 mult=3 forward", int'(count), 4);
  endtask

  task automatic t_dir_ignored();
    mult = 2'd2; single_down = 1; do_clear();
    fwd(6);
    chk("R11 dir ignored", int'(count), 4);
    single_down = 0;
  endtask

  task automatic t_dual();
    mult = 2'd2; do_clear();
    fwd(6);
    step(1, 1, 6);
    chk("R5 no count", int'(count), 4);
    chk("R5 err set", int'(dual_err), 1);
    step(0, 1, 6);
    chk("R5 count resumes", int'(count), 5);
    chk("R5 err sticky", int'(dual_err), 1);
    step(0, 0, 6);
    do_clear();
    chk("R9 err cleared", int'(dual_err), 0);
    chk("R9 count zero", int'(count), 0);
  endtask

  task automatic t_wrap();
    quad_mode = 0; single_down = 0; set_value = 8'sd100; do_clear();
    pulse_a(128);
    chk("R6 up wrap", int'(count), -128);
    single_down = 1; pulse_a(1);
    chk("R6 down wrap", int'(count), 127);
    single_down = 0;
  endtask

  task automatic t_reached_enable();
    quad_mode = 0; single_down = 0; set_value = 8'sd3; do_clear();
    chk("R9 reached on clear nonzero", int'(reached), 0);
    pulse_a(2);
    chk("R8 below", int'(reached), 0);
    pulse_a(1);
    chk("R8 equal", int'(reached), 1);
    pulse_a(1);
    chk("R8 above", int'(reached), 0);
    single_down = 1; pulse_a(1);
    chk("R8 back equal", int'(reached), 1);
    single_down = 0;
    enable = 0;
    pulse_a(2);
    set_value = 8'sd5; cyc(3);
    chk("R7 count held", int'(count), 3);
    chk("R7 flag held", int'(reached), 1);
    set_value = 8'sd0; do_clear();
    chk("R9 clear while disabled", int'(count), 0);
    chk("R9 reached on clear zero", int'(reached), 1);
    enable = 1; cyc(2);
  endtask

  task automatic t_filter();
    quad_mode = 0; single_down = 0; set_value = 8'sd100; filt_len = 11'd20; do_clear();
    step(1, 0, 8); step(0, 0, 40);
    chk("R10 short pulse rejected", int'(count), 0);
    step(1, 0, 30); step(0, 0, 30);
    chk("R10 long pulse counted", int'(count), 1);
    quad_mode = 1; mult = 2'd2; do_clear();
    fwd(3); cyc(5);
    chk("R10 quad bypass", int'(count), 4);
    filt_len = '0;
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1; enable = 1'b1;
    cyc(2);
    t_single();
    t_x1();
    t_x2();
    t_x4();
    t_dir_ignored();
    t_dual();
    t_wrap();
    t_reached_enable();
    t_filter();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule